// File: doc/BRIEF.md
# Multi-Channel DMA Register Engine

This block holds a bank of independent DMA channels behind a small memory-mapped register port. Software loads a channel's start address and byte count, then writes its control register with the enable bit set. From then on the channel asks for word beats on a single shared memory request port. A round-robin arbiter picks which channel's request goes out. Each accepted beat moves the channel's address forward and lowers its byte count.

When the count reaches zero, the channel turns itself off and raises its bit in a shared interrupt status byte. A bus error reported with a beat ends the transfer early and sets an error flag in that channel's control register. Reading the status byte returns the pending bits and clears them in the same access. The final address minus the start address tells software how far the transfer got.

Top module: `dma_chan_bank`

## Requirements
- R1: Reset state: every channel register reads zero, the status byte reads zero, and `irq` and `mem_req` are low.
- R2: Register map: channel `c` owns the 16-byte window at byte address `c<<4`. Offset 0x4 is control, offset 0x8 is address, offset 0xC is count, and offset 0x0 reads zero. The interrupt status byte is at 0x80. Control layout is bit 0 enable, bit 1 transmit, bit 2 mode, bit 3 interrupt enable, bits 7:4 endpoint, bit 8 bus error, bits 10:9 burst type. A control write loads bits 10:9 and 7:0 and clears bit 8.
- R3: A written address keeps bits 1:0 at zero, whatever the written value.
- R4: A channel whose enable bit is set and whose count is non-zero requests beats. When it is selected, `mem_addr`, `mem_tx`, `mem_ep` and `mem_burst` show its address, transmit bit, endpoint and burst type.
- R5: Each beat accepted by `mem_gnt` without `mem_err` adds 4 to the channel's address and subtracts min(4, count) from its count.
- R6: One cycle after an enabled channel's count is zero, the channel has cleared its own enable bit and set its status bit.
- R7: A beat accepted with `mem_err` high leaves the address and count unchanged. It sets control bit 8, clears the enable bit and sets the channel's status bit.
- R8: Reading the status byte returns the pending bits and clears them. A bit set in the same cycle as the read survives and is seen by the next read.
- R9: `irq` is high exactly while some status bit is set whose channel has its interrupt enable bit set.
- R10: Among requesting channels, the arbiter grants the first one after the most recently granted channel, in increasing index order with wrap-around.
- R11: Writing control with enable clear stops a channel's requests on the next cycle. Writing zero to its address and count returns those registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears it) |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| mem_req | output | 1 | A beat is requested |
| mem_ch | output | 3 | Channel that owns the requested beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_tx | output | 1 | 1: memory to endpoint, 0: endpoint to memory |
| mem_ep | output | 4 | Endpoint number of the requesting channel |
| mem_burst | output | 2 | Burst type of the requesting channel |
| mem_gnt | input | 1 | Beat accepted this cycle |
| mem_err | input | 1 | Accepted beat ended in a bus error |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a status read that lands in the same cycle as a channel completing. The set and the clear then hit the status byte on one edge.

The bench gets there by holding back grants until a one-word transfer is armed. It releases exactly one beat, then issues the status read on the cycle between that final beat and the completion edge. It then checks that the read returned nothing and that the next read shows the bit.

Round-robin order is observed by arming two channels while grants are withheld. The bench then records the channel index on consecutive granted beats.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef struct packed {
    logic [4:0] rsvd;
    logic [1:0] burst;
    logic       berr;
    logic [3:0] ep;
    logic       ie;
    logic       mode;
    logic       tx;
    logic       en;
  } dma_ctl_t;

  localparam logic [1:0] OFS_CTL = 2'd1;
  localparam logic [1:0] OFS_ADR = 2'd2;
  localparam logic [1:0] OFS_CNT = 2'd3;
  localparam int unsigned BEAT_BYTES = 4;
endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [IW-1:0] sel,
  output logic          any
);
  logic [IW-1:0] last_q, last_d;

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = N; i >= 1; i--) begin
      logic [IW:0] idx;
      idx = {1'b0, last_q} + (IW+1)'(i);
      if (idx >= (IW+1)'(N)) idx = idx - (IW+1)'(N);
      if (req[idx[IW-1:0]]) begin
        sel = idx[IW-1:0];
        any = 1'b1;
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (adv && any) last_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N-1);
    else        last_q <= last_d;
  end

  assert_sel_requests_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[sel]);
  assert_ptr_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && any) |=> (last_q == $past(sel)));
endmodule

// File: rtl/dma_chan_unit.sv
module dma_chan_unit
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic          wr_adr,
  input  logic          wr_cnt,
  input  logic [31:0]   wdata,
  input  logic          beat,
  input  logic          beat_err,
  output dma_ctl_t      ctl_o,
  output logic [AW-1:0] adr_o,
  output logic [CW-1:0] cnt_o,
  output logic          req_o,
  output logic          done_o
);
  dma_ctl_t      ctl_q, ctl_d;
  logic [AW-1:0] adr_q, adr_d;
  logic [CW-1:0] cnt_q, cnt_d, step;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign step     = (cnt_q >= CW'(BEAT_BYTES)) ? CW'(BEAT_BYTES) : cnt_q;
  assign req_o    = ctl_q.en && !cnt_zero;
  assign done_o   = ctl_q.en && !wr_ctl && (cnt_zero || (beat && beat_err));

  always_comb begin
    ctl_d = ctl_q;
    adr_d = adr_q;
    cnt_d = cnt_q;
    if (beat && req_o) begin
      if (beat_err) begin
        ctl_d.berr = 1'b1;
        ctl_d.en   = 1'b0;
      end else begin
        adr_d = adr_q + AW'(BEAT_BYTES);
        cnt_d = cnt_q - step;
      end
    end else if (ctl_q.en && cnt_zero) begin
      ctl_d.en = 1'b0;
    end
    if (wr_ctl) begin
      ctl_d       = dma_ctl_t'(wdata[15:0]);
      ctl_d.rsvd  = '0;
      ctl_d.berr  = 1'b0;
    end
    if (wr_adr) adr_d = {wdata[AW-1:2], 2'b00};
    if (wr_cnt) cnt_d = wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      adr_q <= '0;
      cnt_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      adr_q <= adr_d;
      cnt_q <= cnt_d;
    end
  end

  assign ctl_o = ctl_q;
  assign adr_o = adr_q;
  assign cnt_o = cnt_q;

  assert_adr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adr_q[1:0] == 2'b00);
  assert_cnt_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt_q <= $past(cnt_q)));
  assert_self_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wr_ctl) |=> !ctl_q.en);
  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && req_o && beat_err && !wr_cnt && !wr_adr) |=> ($stable(cnt_q) && $stable(adr_q)));
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_chan_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 32,
  parameter int unsigned CW  = 32,
  localparam int unsigned IW = $clog2(NCH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [2:0]  mem_ch,
  output logic [31:0] mem_addr,
  output logic        mem_tx,
  output logic [3:0]  mem_ep,
  output logic [1:0]  mem_burst,
  input  logic        mem_gnt,
  input  logic        mem_err,
  output logic        irq
);
  dma_ctl_t        ctl_w [NCH];
  logic [AW-1:0]   adr_w [NCH];
  logic [CW-1:0]   cnt_w [NCH];
  logic [NCH-1:0]  req_w, done_w, ie_w;
  logic [NCH-1:0]  stat_q, stat_d;
  logic [IW-1:0]   sel, wch;
  logic            any, stat_hit, stat_rd;
  logic [1:0]      ofs;

  assign stat_hit = (reg_addr == 8'h80);
  assign stat_rd  = reg_rd && stat_hit;
  assign wch      = reg_addr[4 +: IW];
  assign ofs      = reg_addr[3:2];

  dma_rr_arb #(.N(NCH)) arb_i (
    .clk(clk), .rst_n(rst_n), .req(req_w), .adv(mem_gnt), .sel(sel), .any(any)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wsel;
    assign wsel = reg_wr && !reg_addr[7] && (wch == IW'(c));
    dma_chan_unit #(.AW(AW), .CW(CW)) ch_i (
      .clk(clk), .rst_n(rst_n),
      .wr_ctl(wsel && ofs == OFS_CTL),
      .wr_adr(wsel && ofs == OFS_ADR),
      .wr_cnt(wsel && ofs == OFS_CNT),
      .wdata(reg_wdata),
      .beat(mem_gnt && any && (sel == IW'(c))),
      .beat_err(mem_err),
      .ctl_o(ctl_w[c]), .adr_o(adr_w[c]), .cnt_o(cnt_w[c]),
      .req_o(req_w[c]), .done_o(done_w[c])
    );
    assign ie_w[c] = ctl_w[c].ie;
  end

  always_comb begin
    stat_d = stat_rd ? '0 : stat_q;
    stat_d = stat_d | done_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (stat_hit) reg_rdata = 32'(stat_q);
    else if (!reg_addr[7]) begin
      case (ofs)
        OFS_CTL: reg_rdata = 32'(ctl_w[wch]);
        OFS_ADR: reg_rdata = 32'(adr_w[wch]);
        OFS_CNT: reg_rdata = 32'(cnt_w[wch]);
        default: reg_rdata = '0;
      endcase
    end
  end

  assign mem_req   = any;
  assign mem_ch    = 3'(sel);
  assign mem_addr  = 32'(adr_w[sel]);
  assign mem_tx    = ctl_w[sel].tx;
  assign mem_ep    = ctl_w[sel].ep;
  assign mem_burst = ctl_w[sel].burst;
  assign irq       = |(stat_q & ie_w);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && done_w == '0) |=> (stat_q == '0));
  assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w != '0) |=> ((stat_q & $past(done_w)) == $past(done_w)));
endmodule

// File: tb/dma_chan_bank_tb_top.sv
module dma_chan_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, mem_gnt = 0, mem_err = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata, mem_addr;
  logic        mem_req, mem_tx, irq;
  logic [2:0]  mem_ch;
  logic [3:0]  mem_ep;
  logic [1:0]  mem_burst;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_chan_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_ch(mem_ch),
    .mem_addr(mem_addr), .mem_tx(mem_tx), .mem_ep(mem_ep), .mem_burst(mem_burst),
    .mem_gnt(mem_gnt), .mem_err(mem_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    rd(8'h84, v); chk("R1 ctl", v, 0);
    rd(8'h08, v); chk("R1 adr", v, 0);
    rd(8'h80, v); chk("R1 status", v, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    wr(8'h08, 32'h0000_1003);
    rd(8'h08, v); chk("R3 low bits dropped", v, 32'h1000);
    wr(8'h0C, 12);
    wr(8'h04, 32'h0000_063B);
    @(negedge clk); #1;
    chk("R4 mem_req", 32'(mem_req), 1);
    chk("R4 mem_addr", mem_addr, 32'h1000);
    chk("R4 mem_ep", 32'(mem_ep), 3);
    chk("R4 mem_tx", 32'(mem_tx), 1);
    chk("R4 mem_burst", 32'(mem_burst), 3);
    mem_gnt = 1;
    @(negedge clk); #1;
    chk("R5 addr after beat", mem_addr, 32'h1004);
    repeat (4) @(negedge clk);
    mem_gnt = 0;
    rd(8'h08, v); chk("R5 final addr", v, 32'h100C);
    rd(8'h0C, v); chk("R5 final count", v, 0);
    rd(8'h04, v); chk("R6 enable self-cleared R2 layout", v, 32'h063A);
    chk("R9 irq set", 32'(irq), 1);
    rd(8'h80, v); chk("R8 status read", v, 32'h01);
    rd(8'h80, v); chk("R8 status cleared", v, 0);
    chk("R9 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_rr();
    logic [2:0] seq [4];
    logic [31:0] v;
    wr(8'h1C, 8); wr(8'h2C, 8);
    wr(8'h14, 32'h9); wr(8'h24, 32'h9);
    @(negedge clk); mem_gnt = 1;
    for (int i = 0; i < 4; i++) begin
      #1 seq[i] = mem_ch;
      @(negedge clk);
    end
    mem_gnt = 0;
    chk("R10 beat0", 32'(seq[0]), 1);
    chk("R10 beat1", 32'(seq[1]), 2);
    chk("R10 beat2", 32'(seq[2]), 1);
    chk("R10 beat3", 32'(seq[3]), 2);
    repeat (2) @(negedge clk);
    rd(8'h80, v); chk("R6 both done", v, 32'h06);
  endtask

  task automatic t_err();
    logic [31:0] v;
    wr(8'h38, 32'h2000); wr(8'h3C, 16); wr(8'h34, 32'h9);
    @(negedge clk); mem_gnt = 1; mem_err = 1;
    @(negedge clk); mem_gnt = 0; mem_err = 0;
    rd(8'h34, v); chk("R7 berr set en clear", v, 32'h108);
    rd(8'h3C, v); chk("R7 count held", v, 16);
    rd(8'h38, v); chk("R7 addr held", v, 32'h2000);
    chk("R9 irq on error", 32'(irq), 1);
    rd(8'h80, v); chk("R7 status", v, 32'h08);
    wr(8'h34, 32'h8);
    rd(8'h34, v); chk("R2 write clears bit8", v, 32'h8);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(8'h48, 32'h3000); wr(8'h4C, 64); wr(8'h44, 32'h1);
    @(negedge clk); #1 chk("R11 requesting", 32'(mem_req), 1);
    wr(8'h44, 0); wr(8'h48, 0); wr(8'h4C, 0);
    #1 chk("R11 request stopped", 32'(mem_req), 0);
    rd(8'h44, v); chk("R11 ctl zero", v, 0);
    rd(8'h48, v); chk("R11 addr zero", v, 0);
    rd(8'h4C, v); chk("R11 count zero", v, 0);
    rd(8'h40, v); chk("R2 offset0 zero", v, 0);
  endtask

  task automatic t_noie();
    logic [31:0] v;
    wr(8'h5C, 6); wr(8'h54, 32'h1);
    @(negedge clk); mem_gnt = 1;
    repeat (2) @(negedge clk); mem_gnt = 0;
    repeat (2) @(negedge clk);
    rd(8'h58, v); chk("R5 partial word addr", v, 8);
    chk("R9 irq masked", 32'(irq), 0);
    rd(8'h80, v); chk("R6 status without ie", v, 32'h20);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(8'h6C, 4); wr(8'h64, 32'h1);
    @(negedge clk); mem_gnt = 1;
    @(negedge clk); mem_gnt = 0;
    reg_rd = 1; reg_addr = 8'h80; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
    chk("R8 read before completion", v, 0);
    rd(8'h80, v); chk("R8 same-cycle set kept", v, 32'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_rr();
    t_err();
    t_abort();
    t_noie();
    t_race();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule